// File: doc/BRIEF.md
# Adaptive Dead-Time Half-Bridge Gate Controller

This block turns a single pulse-width request into two registered gate commands for a half-bridge: one for the high-side switch and one for the low-side switch. It never lets both commands be active together. Before either command turns on, the block waits for feedback from the power stage. The high side waits until the sensed low-side gate has actually discharged. The low side waits until the switch node has actually fallen. On top of that feedback, a minimum number of idle clock cycles is enforced. Both feedback signals come from outside the clock domain and pass through a synchronizer chain.

There are three control inputs. The enable input turns both gates off. The synchronous-rectifier select decides whether the low-side switch conducts during the off phase of the request. The active-low clamp input overrides every other input and holds the low-side switch on, which protects the output against a shorted high-side switch. A build-time parameter selects the polarity of the request input. If the awaited feedback does not arrive within a set number of cycles, the controller parks both gates off and raises a sticky fault flag. The flag clears when enable is dropped.

Top module: `deadtime_gate_ctrl`

## Requirements
- R1: While `clamp_n` is 0, `lo_gate` is 1 and `hi_gate` is 0 from the next clock edge on, whatever `enable`, `sync_mode`, `pwm_in` and `fault` are.
- R2: While `clamp_n` is 1 and `enable` is 0, both gates are 0 from the next clock edge.
- R3: While `clamp_n` is 1 and `sync_mode` is 0, `lo_gate` is 0 from the next clock edge on.
- R4: With `sync_mode` 1 and the request in its off phase, `lo_gate` turns on once the turn-on conditions are met, so the low-side switch acts as a synchronous rectifier.
- R5: `hi_gate` rises only on an edge where the synchronized `lo_gate_sense` (1 = low-side gate charged) reads 0. The sense inputs reach the decision through `SYNC_STAGES` flops.
- R6: `lo_gate` rises, other than through the clamp, only on an edge where the synchronized `sw_node_low` (1 = switch node low) reads 1.
- R7: With `INVERT_PWM` = 0, `pwm_in` = 1 requests the high-side on-phase. With `INVERT_PWM` = 1, `pwm_in` = 0 requests it.
- R8: A gate turns on no earlier than the edge that ends `MIN_DEAD` cycles spent waiting with both gates off. With feedback already satisfied, a new request seen at edge k gives the gate at edge k+`MIN_DEAD`.
- R9: If the feedback does not arrive within `TIMEOUT` waiting cycles, `fault` becomes 1 at the edge that ends the `TIMEOUT`-th cycle. Both gates then stay 0 (the clamp excepted) until `fault` clears, which happens one edge after `enable` is 0.
- R10: `hi_gate` and `lo_gate` are never 1 in the same cycle, and both are register outputs.
- R11: If the request flips while a turn-on is pending, the pending turn-on is dropped. The wait restarts, with a fresh dead-time count, for the opposite side (or ends off when `sync_mode` is 0).
- R12: After reset, `hi_gate`, `lo_gate` and `fault` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pwm_in | input | 1 | Pulse-width request; polarity set by `INVERT_PWM` |
| enable | input | 1 | 0 forces both gates off and clears the fault |
| sync_mode | input | 1 | 1 lets the low side act as a synchronous rectifier |
| clamp_n | input | 1 | Active-low protection clamp; forces the low side on |
| lo_gate_sense | input | 1 | Asynchronous sensed low-side gate level, 1 = charged |
| sw_node_low | input | 1 | Asynchronous sensed switch-node flag, 1 = node low |
| hi_gate | output | 1 | High-side gate command |
| lo_gate | output | 1 | Low-side gate command |
| fault | output | 1 | Sticky feedback-timeout flag |

## Verification
A wrong controller state shows at the gate pins on the very next edge. A missed clamp or enable response, or an overlap of the two gates, appears one cycle after the causing input. A wait counter that is off by one moves the turn-on edge by exactly one cycle, so the bench samples the gates at the precise edge predicted from `MIN_DEAD` and the synchronizer depth. A stuck or mis-cleared fault shows on the `fault` pin `TIMEOUT` cycles into a blocked wait, or one edge after enable drops. A second instance built with the opposite polarity is compared cycle by cycle against its own model. This exposes a request that is decoded the wrong way round.

// File: rtl/deadtime_gate_pkg.sv
package deadtime_gate_pkg;

  typedef enum logic [2:0] {
    DRV_IDLE   = 3'd0,
    DRV_HI_ARM = 3'd1,
    DRV_HI_ON  = 3'd2,
    DRV_LO_ARM = 3'd3,
    DRV_LO_ON  = 3'd4,
    DRV_CLAMP  = 3'd5
  } drv_state_e;

endpackage

// File: rtl/dtg_sync.sv
module dtg_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= RST_VAL;
        else        chain[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= RST_VAL;
        else        chain[g] <= chain[g-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dtg_wait_timer.sv
module dtg_wait_timer #(
  parameter int MIN_DEAD = 4,
  parameter int TIMEOUT  = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic dead_met,
  output logic expired
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] DEAD_LAST = CW'(MIN_DEAD - 1);
  localparam logic [CW-1:0] TO_LAST   = CW'(TIMEOUT - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  // Count cycles spent in a waiting state; saturate at the timeout limit.
  always_comb begin
    cnt_en = restart || (run && (cnt_q != TO_LAST));
    cnt_d  = restart ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign dead_met = (cnt_q >= DEAD_LAST);
  assign expired  = (cnt_q >= TO_LAST);
endmodule

// File: rtl/dtg_fsm.sv
module dtg_fsm
  import deadtime_gate_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_hi,
  input  logic enable,
  input  logic sync_mode,
  input  logic clamp_n,
  input  logic gate_low,
  input  logic node_low,
  input  logic dead_met,
  input  logic expired,
  output logic timer_restart,
  output logic timer_run,
  output logic hi_gate,
  output logic lo_gate,
  output logic fault
);
  drv_state_e state_q, state_d;
  logic       tmo_hit;
  logic       fault_d;

  // Next-state selection; clamp first, then enable, then fault lockout.
  always_comb begin
    state_d = state_q;
    tmo_hit = 1'b0;
    if (!clamp_n) begin
      state_d = DRV_CLAMP;
    end else if (!enable || fault) begin
      state_d = DRV_IDLE;
    end else begin
      unique case (state_q)
        DRV_IDLE:   state_d = req_hi ? DRV_HI_ARM : (sync_mode ? DRV_LO_ARM : DRV_IDLE);
        DRV_CLAMP:  state_d = DRV_IDLE;
        DRV_HI_ARM: begin
          if (!req_hi)                   state_d = sync_mode ? DRV_LO_ARM : DRV_IDLE;
          else if (gate_low && dead_met) state_d = DRV_HI_ON;
          else if (expired) begin
            state_d = DRV_IDLE;
            tmo_hit = 1'b1;
          end
        end
        DRV_HI_ON:  if (!req_hi) state_d = sync_mode ? DRV_LO_ARM : DRV_IDLE;
        DRV_LO_ARM: begin
          if (req_hi)                    state_d = DRV_HI_ARM;
          else if (!sync_mode)           state_d = DRV_IDLE;
          else if (node_low && dead_met) state_d = DRV_LO_ON;
          else if (expired) begin
            state_d = DRV_IDLE;
            tmo_hit = 1'b1;
          end
        end
        DRV_LO_ON: begin
          if (req_hi)          state_d = DRV_HI_ARM;
          else if (!sync_mode) state_d = DRV_IDLE;
        end
        default:    state_d = DRV_IDLE;
      endcase
    end
  end

  always_comb begin
    if (!enable)      fault_d = 1'b0;
    else if (tmo_hit) fault_d = 1'b1;
    else              fault_d = fault;
  end

  assign timer_restart = (state_d != state_q);
  assign timer_run     = (state_q == DRV_HI_ARM) || (state_q == DRV_LO_ARM);

  // State and gate registers: gates decoded from the next state, registered.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DRV_IDLE;
      hi_gate <= 1'b0;
      lo_gate <= 1'b0;
      fault   <= 1'b0;
    end else begin
      state_q <= state_d;
      hi_gate <= (state_d == DRV_HI_ON);
      lo_gate <= (state_d == DRV_LO_ON) || (state_d == DRV_CLAMP);
      fault   <= fault_d;
    end
  end
endmodule

// File: rtl/deadtime_gate_ctrl.sv
module deadtime_gate_ctrl #(
  parameter bit INVERT_PWM  = 1'b0,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_DEAD    = 4,
  parameter int TIMEOUT     = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_in,
  input  logic enable,
  input  logic sync_mode,
  input  logic clamp_n,
  input  logic lo_gate_sense,
  input  logic sw_node_low,
  output logic hi_gate,
  output logic lo_gate,
  output logic fault
);
  logic req_hi;
  logic gate_chg_s;
  logic gate_low_s;
  logic node_low_s;
  logic tmr_restart;
  logic tmr_run;
  logic dead_met;
  logic expired;

  if (INVERT_PWM) begin : g_inv
    assign req_hi = ~pwm_in;
  end else begin : g_dir
    assign req_hi = pwm_in;
  end

  // Reset to the unsafe reading so nothing turns on before the chain fills.
  dtg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_gate_sync (
    .clk(clk), .rst_n(rst_n), .d(lo_gate_sense), .q(gate_chg_s)
  );
  dtg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_node_sync (
    .clk(clk), .rst_n(rst_n), .d(sw_node_low), .q(node_low_s)
  );
  assign gate_low_s = ~gate_chg_s;

  dtg_wait_timer #(.MIN_DEAD(MIN_DEAD), .TIMEOUT(TIMEOUT)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(tmr_restart), .run(tmr_run),
    .dead_met(dead_met), .expired(expired)
  );

  dtg_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req_hi(req_hi), .enable(enable),
    .sync_mode(sync_mode), .clamp_n(clamp_n), .gate_low(gate_low_s),
    .node_low(node_low_s), .dead_met(dead_met), .expired(expired),
    .timer_restart(tmr_restart), .timer_run(tmr_run),
    .hi_gate(hi_gate), .lo_gate(lo_gate), .fault(fault)
  );
endmodule

// File: rtl/deadtime_gate_ctrl_chk.sv
module deadtime_gate_ctrl_chk #(
  parameter int MIN_DEAD = 4
) (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic sync_mode,
  input logic clamp_n,
  input logic hi_gate,
  input logic lo_gate,
  input logic fault,
  input logic gate_low_s,
  input logic node_low_s
);
  localparam int QW = $clog2(MIN_DEAD + 1);
  localparam logic [QW-1:0] QMAX = QW'(MIN_DEAD);

  logic [QW-1:0] quiet_q;

  // Consecutive cycles observed with both gates off.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                quiet_q <= '0;
    else if (hi_gate || lo_gate) quiet_q <= '0;
    else if (quiet_q != QMAX)  quiet_q <= quiet_q + 1'b1;
  end

  a_r1_clamp_wins: assert property (@(posedge clk) disable iff (!rst_n)
    !clamp_n |=> (lo_gate && !hi_gate));
  a_r2_disable_off: assert property (@(posedge clk) disable iff (!rst_n)
    (clamp_n && !enable) |=> (!hi_gate && !lo_gate));
  a_r3_async_low_off: assert property (@(posedge clk) disable iff (!rst_n)
    (clamp_n && !sync_mode) |=> !lo_gate);
  a_r5_hi_after_gate_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi_gate) |-> $past(gate_low_s));
  a_r6_lo_after_node_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(lo_gate) && $past(clamp_n)) |-> $past(node_low_s));
  a_r8_min_dead_hi: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi_gate) |-> (quiet_q >= QMAX));
  a_r9_fault_blocks_hi: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !hi_gate);
  a_r9_fault_clear_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault) |-> $past(!enable));
  a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_gate && lo_gate));
endmodule

bind deadtime_gate_ctrl deadtime_gate_ctrl_chk #(.MIN_DEAD(MIN_DEAD)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .sync_mode(sync_mode),
  .clamp_n(clamp_n), .hi_gate(hi_gate), .lo_gate(lo_gate), .fault(fault),
  .gate_low_s(gate_low_s), .node_low_s(node_low_s)
);

// File: tb/tb_deadtime_gate_ctrl.sv
module tb_deadtime_gate_ctrl;
  localparam int MD = 4;
  localparam int TO = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm_in = 1'b0, enable = 1'b0, sync_mode = 1'b0, clamp_n = 1'b1;
  logic lo_gate_sense = 1'b0, sw_node_low = 1'b1;
  logic hi0, lo0, f0, hi1, lo1, f1;
  int   total = 0, fails = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  deadtime_gate_ctrl #(.INVERT_PWM(1'b0), .MIN_DEAD(MD), .TIMEOUT(TO)) dut (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .enable(enable),
    .sync_mode(sync_mode), .clamp_n(clamp_n), .lo_gate_sense(lo_gate_sense),
    .sw_node_low(sw_node_low), .hi_gate(hi0), .lo_gate(lo0), .fault(f0));
  deadtime_gate_ctrl #(.INVERT_PWM(1'b1), .MIN_DEAD(MD), .TIMEOUT(TO)) dut_inv (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .enable(enable),
    .sync_mode(sync_mode), .clamp_n(clamp_n), .lo_gate_sense(lo_gate_sense),
    .sw_node_low(sw_node_low), .hi_gate(hi1), .lo_gate(lo1), .fault(f1));

  // Phases: 0 idle, 1 arm-high, 2 high on, 3 arm-low, 4 low on, 5 clamp.
  typedef struct {
    int ph; int cnt; bit flt; bit a1, a2, b1, b2; bit hi, lo;
  } mdl_t;
  mdl_t m0, m1;

  function automatic mdl_t mreset();
    mdl_t r;
    r.ph = 0; r.cnt = 0; r.flt = 0; r.a1 = 1; r.a2 = 1; r.b1 = 0; r.b2 = 0;
    r.hi = 0; r.lo = 0;
    return r;
  endfunction

  function automatic mdl_t mstep(mdl_t m, bit inv);
    mdl_t n = m;
    bit req = pwm_in ^ inv;
    bit waitok = (m.cnt >= MD - 1);
    bit tmo = 0;
    int nx = m.ph;
    n.a1 = lo_gate_sense; n.a2 = m.a1; n.b1 = sw_node_low; n.b2 = m.b1;
    if (!clamp_n) nx = 5;
    else if (!enable || m.flt) nx = 0;
    else begin
      case (m.ph)
        0: nx = req ? 1 : (sync_mode ? 3 : 0);
        5: nx = 0;
        1: if (!req) nx = sync_mode ? 3 : 0;
           else if (!m.a2 && waitok) nx = 2;
           else if (m.cnt >= TO - 1) begin nx = 0; tmo = 1; end
        2: if (!req) nx = sync_mode ? 3 : 0;
        3: if (req) nx = 1;
           else if (!sync_mode) nx = 0;
           else if (m.b2 && waitok) nx = 4;
           else if (m.cnt >= TO - 1) begin nx = 0; tmo = 1; end
        4: if (req) nx = 1; else if (!sync_mode) nx = 0;
        default: nx = 0;
      endcase
    end
    if (!enable) n.flt = 0; else if (tmo) n.flt = 1;
    if (nx != m.ph) n.cnt = 0;
    else if ((m.ph == 1 || m.ph == 3) && m.cnt < TO - 1) n.cnt = m.cnt + 1;
    n.ph = nx; n.hi = (nx == 2); n.lo = (nx == 4 || nx == 5);
    return n;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin m0 = mreset(); m1 = mreset(); end
    else begin m0 = mstep(m0, 1'b0); m1 = mstep(m1, 1'b1); end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic string tag_of(mdl_t m);
    if (!clamp_n) return "R1";
    if (!enable) return "R2";
    if (m.flt) return "R9";
    return "R10";
  endfunction

  // Cycle-by-cycle comparison of both instances against their models.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk({hi0, lo0, f0} == {m0.hi, m0.lo, m0.flt}, tag_of(m0), "gates/fault",
          int'({hi0, lo0, f0}), int'({m0.hi, m0.lo, m0.flt}));
      chk({hi1, lo1, f1} == {m1.hi, m1.lo, m1.flt}, "R7", "inverted instance",
          int'({hi1, lo1, f1}), int'({m1.hi, m1.lo, m1.flt}));
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic report();
    done = 1'b1;
    $display("  %0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    #2_000_000;
    chk(1'b0, "R10", "watchdog expired", 0, 1);
    report();
  end

  initial begin
    void'($urandom(32'h1d5e_a7c3));
    tick(3);
    chk({hi0, lo0, f0} == 3'b000, "R12", "reset outputs", int'({hi0, lo0, f0}), 0);
    rst_n = 1'b1;
    tick(1);
    chk({hi0, lo0, f0} == 3'b000, "R12", "after release", int'({hi0, lo0, f0}), 0);

    // R8/R5: high-side turn-on timing with feedback already satisfied.
    enable = 1; sync_mode = 0; pwm_in = 0; lo_gate_sense = 0; sw_node_low = 1;
    tick(5);
    pwm_in = 1;
    tick(MD);
    chk(hi0 == 0, "R8", "hi before dead time", hi0, 0);
    tick(1);
    chk(hi0 == 1, "R5", "hi after dead time", hi0, 1);

    // R4: synchronous rectifier in the off phase.
    sync_mode = 1; pwm_in = 0;
    tick(1);
    chk(hi0 == 0, "R4", "hi off at request drop", hi0, 0);
    tick(MD - 1);
    chk(lo0 == 0, "R8", "lo before dead time", lo0, 0);
    tick(1);
    chk(lo0 == 1, "R4", "lo rectifier on", lo0, 1);

    // R6: low side waits for the switch node.
    sw_node_low = 0; pwm_in = 1;
    tick(MD + 1);
    chk(hi0 == 1, "R5", "hi on again", hi0, 1);
    pwm_in = 0;
    tick(10);
    chk(lo0 == 0, "R6", "lo held while node high", lo0, 0);
    sw_node_low = 1;
    tick(2);
    chk(lo0 == 0, "R6", "lo within sync latency", lo0, 0);
    tick(1);
    chk(lo0 == 1, "R6", "lo after node low", lo0, 1);

    // R11: abandon a pending high-side turn-on.
    lo_gate_sense = 1; pwm_in = 1;
    tick(3);
    chk({hi0, lo0} == 2'b00, "R11", "pending high blocked", int'({hi0, lo0}), 0);
    pwm_in = 0;
    tick(MD);
    chk(lo0 == 0, "R11", "fresh dead time low", lo0, 0);
    tick(1);
    chk(lo0 == 1, "R11", "low after abandon", lo0, 1);

    // R9: timeout, sticky fault, clear on enable low.
    pwm_in = 1;
    tick(TO);
    chk(f0 == 0, "R9", "fault before timeout", f0, 0);
    tick(1);
    chk(f0 == 1, "R9", "fault at timeout", f0, 1);
    lo_gate_sense = 0;
    tick(4); pwm_in = 0; tick(6); pwm_in = 1; tick(6);
    chk({hi0, lo0, f0} == 3'b001, "R9", "sticky fault keeps off", int'({hi0, lo0, f0}), 1);
    enable = 0;
    tick(1);
    chk(f0 == 0, "R9", "fault cleared", f0, 0);

    // R3: non-synchronous mode keeps low side off.
    enable = 1; sync_mode = 0; pwm_in = 0;
    for (int i = 0; i < 20; i++) begin
      tick(1);
      chk(lo0 == 0, "R3", "lo in async mode", lo0, 0);
    end
    chk(hi1 == 1 && hi0 == 0, "R7", "inverted request high side", int'({hi1, hi0}), 2);

    // R1/R2: clamp override and disable.
    enable = 0; clamp_n = 0; pwm_in = 1;
    tick(1);
    chk({hi0, lo0} == 2'b01, "R1", "clamp while disabled", int'({hi0, lo0}), 1);
    enable = 1; tick(3);
    chk({hi0, lo0} == 2'b01, "R1", "clamp while requesting high", int'({hi0, lo0}), 1);
    clamp_n = 1; enable = 0;
    tick(1);
    chk({hi0, lo0} == 2'b00, "R2", "disable turns both off", int'({hi0, lo0}), 0);

    // Random traffic against the models; sense follows the gates with noise.
    enable = 1;
    for (int i = 0; i < 6000; i++) begin
      tick(1);
      if ($urandom_range(7) == 0) pwm_in = ~pwm_in;
      if ($urandom_range(60) == 0) sync_mode = ~sync_mode;
      enable  = ($urandom_range(150) != 0);
      clamp_n = ($urandom_range(300) != 0);
      lo_gate_sense = ($urandom_range(15) == 0) ? 1'b1 : lo0;
      sw_node_low   = ($urandom_range(15) == 0) ? 1'b0 : ~hi0;
      if (i % 1500 > 1400) lo_gate_sense = 1'b1;
    end
    report();
  end
endmodule